// File: doc/BRIEF.md
# Bridge Type-1 Configuration Register File

This block holds the configuration header of a bus-to-bus bridge: the three bus numbers, the secondary latency timer, the I/O, memory and prefetchable forwarding windows with their upper extensions, the command and bridge-control words, and the fixed identity fields (header type, class code, primary and secondary status). Software reaches it through a dword-indexed port. A write carries four byte enables, and each register bit is guarded by its own write mask. The read data is a combinational view of the addressed dword.

Writes that can change how the bridge forwards raise a one-cycle `map_update` strobe. Such writes are those that touch the command word, the window bytes or the control word. Downstream logic uses the strobe to recompute its decoders. Setting the bus-reset bit in the control word from 0 to 1 pulses `sec_bus_rst` for one cycle. A separate `fwd_close` command makes every window empty in one cycle.

Top module: `bridge_cfg_regs`

## Requirements
- R1: While reset is asserted, and afterwards until written, the bus numbers, the latency timer, the command, the bridge control, all writable window bits and both prefetchable upper words read zero. The fixed bits keep their values: the I/O base and limit read 0x01, and the prefetchable base and limit read 0x0001.
- R2: Dword 6 holds the primary (lane 0), secondary (lane 1) and subordinate (lane 2) bus numbers and the secondary latency timer (lane 3). All four bytes are fully writable. Each byte changes only when its byte enable is set.
- R3: In dword 7, the I/O base (lane 0) and I/O limit (lane 1) are writable in bits [7:4], and their low nibble reads 0x1. In dword 8, the memory base [15:0] and limit [31:16] are writable in bits [15:4], and bits [3:0] read 0. In dword 9, the prefetchable base [15:0] and limit [31:16] are writable in bits [15:4], and bits [3:0] read 0x1. Dwords 10 and 11 (prefetchable upper base and upper limit) are fully writable, and so is dword 12 (I/O upper base [15:0], upper limit [31:16]).
- R4: Dword 1 holds the command in [15:0], with only bits [2:0] writable. Its status half [31:16] reads 0x00A0, with the 66 MHz bit (5) and the fast back-to-back bit (7) set. The secondary status in dword 7 [31:16] also reads 0x00A0.
- R5: Dword 15 holds the bridge control in [31:16], with bits [6:0] writable and the rest reading zero. Bit 6 is the secondary bus reset bit.
- R6: Dword 2 reads 0x06040000, the bridge class code. Dword 3 reads the header type in lane 2 as 0x01, with bit 7 equal to the MULTI_FN parameter. The other bytes of both dwords read zero.
- R7: Dwords 0, 4, 5, 13 and 14, and lanes 0 and 1 of dword 15, read zero, and writes to them have no effect.
- R8: `map_update` is high for exactly the cycle after a write edge whose enabled bytes include any of these byte offsets: 0x04, 0x05, 0x1C, 0x1D, 0x20 to 0x33, 0x3E, 0x3F. The masks do not matter, and no other event raises it.
- R9: `sec_bus_rst` is high for exactly the cycle after a write that changes control bit 6 from 0 to 1. Rewriting the bit while it is already 1 gives no pulse.
- R10: `fwd_close` sets the writable bits of the I/O, memory and prefetchable base fields, clears the writable bits of the three limit fields, and clears dwords 10 and 11. It takes priority over a write to those fields in the same cycle, and it does not raise `map_update`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | AW | Dword index for reads and writes |
| cfg_wr | input | 1 | Write strobe, sampled at the clock edge |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Contents of the addressed dword |
| fwd_close | input | 1 | Make every forwarding window empty |
| map_update | output | 1 | One-cycle pulse after a window-affecting write |
| sec_bus_rst | output | 1 | One-cycle secondary bus reset pulse |

## Verification
The assertions take for granted that `cfg_wr` and `fwd_close` are held low throughout reset. The only other way the control word can change is a port write, so a reset pulse can never repeat in the next cycle and is always accompanied by an update strobe. The stimulus drives every input at the falling edge and returns `cfg_wr` and `fwd_close` low after each operation. The random traffic spans the full dword range, every byte-enable pattern, and occasional close commands that coincide with writes.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;

    // dword indices of the implemented registers
    localparam int DW_CMD    = 1;
    localparam int DW_CLASS  = 2;
    localparam int DW_HDR    = 3;
    localparam int DW_BUS    = 6;
    localparam int DW_IO     = 7;
    localparam int DW_MEM    = 8;
    localparam int DW_PF     = 9;
    localparam int DW_PFB_HI = 10;
    localparam int DW_PFL_HI = 11;
    localparam int DW_IO_HI  = 12;
    localparam int DW_CTL    = 15;

    localparam logic [15:0] CMD_WM  = 16'h0007;
    localparam logic [7:0]  IO_WM   = 8'hF0;
    localparam logic [15:0] MEM_WM  = 16'hFFF0;
    localparam logic [15:0] PF_WM   = 16'hFFF0;
    localparam logic [15:0] CTL_WM  = 16'h007F;
    localparam logic [15:0] STAT_RO = 16'h00A0;
    localparam logic [7:0]  IO_TYP  = 8'h01;
    localparam logic [15:0] PF_TYP  = 16'h0001;
    localparam int          CTL_SBR = 6;

    typedef struct packed {
        logic [15:0] cmd;
        logic [7:0]  pri_bus;
        logic [7:0]  sec_bus;
        logic [7:0]  sub_bus;
        logic [7:0]  sec_lat;
        logic [7:0]  io_base;
        logic [7:0]  io_lim;
        logic [15:0] mem_base;
        logic [15:0] mem_lim;
        logic [15:0] pf_base;
        logic [15:0] pf_lim;
        logic [31:0] pf_base_hi;
        logic [31:0] pf_lim_hi;
        logic [15:0] io_base_hi;
        logic [15:0] io_lim_hi;
        logic [15:0] bctl;
    } regs_t;

    function automatic logic [7:0] mrg8(logic [7:0] old, logic [7:0] wd,
                                        logic en, logic [7:0] mask);
        return en ? ((old & ~mask) | (wd & mask)) : old;
    endfunction

    function automatic logic [15:0] mrg16(logic [15:0] old, logic [15:0] wd,
                                          logic [1:0] en, logic [15:0] mask);
        return {mrg8(old[15:8], wd[15:8], en[1], mask[15:8]),
                mrg8(old[7:0],  wd[7:0],  en[0], mask[7:0])};
    endfunction

    function automatic logic [31:0] mrg32(logic [31:0] old, logic [31:0] wd,
                                          logic [3:0] en);
        return {mrg16(old[31:16], wd[31:16], en[3:2], 16'hFFFF),
                mrg16(old[15:0],  wd[15:0],  en[1:0], 16'hFFFF)};
    endfunction

endpackage

// File: rtl/bcfg_touch.sv
module bcfg_touch #(
    parameter int AW = 4
) (
    input  logic [AW-1:0] addr,
    input  logic [3:0]    be,
    input  logic          wr,
    output logic          touch
);
    localparam int NB = 4;

    function automatic logic in_set(int ba);
        return (ba == 4) || (ba == 5) || (ba == 28) || (ba == 29) ||
               (ba >= 32 && ba <= 51) || (ba == 62) || (ba == 63);
    endfunction

    logic [NB-1:0] lane_hit;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [AW+1:0] ba;
        assign ba          = {addr, 2'(i)};
        assign lane_hit[i] = be[i] & in_set(int'(ba));
    end

    assign touch = wr & (|lane_hit);

endmodule

// File: rtl/bcfg_rdmux.sv
module bcfg_rdmux
    import bcfg_pkg::*;
#(
    parameter int   AW       = 4,
    parameter logic MULTI_FN = 1'b0
) (
    input  regs_t         st,
    input  logic [AW-1:0] addr,
    output logic [31:0]   rdata
);
    always_comb begin
        case (int'(addr))
            DW_CMD:    rdata = {STAT_RO, st.cmd};
            DW_CLASS:  rdata = 32'h0604_0000;
            DW_HDR:    rdata = {8'h00, MULTI_FN, 7'h01, 16'h0000};
            DW_BUS:    rdata = {st.sec_lat, st.sub_bus, st.sec_bus, st.pri_bus};
            DW_IO:     rdata = {STAT_RO, st.io_lim | IO_TYP, st.io_base | IO_TYP};
            DW_MEM:    rdata = {st.mem_lim, st.mem_base};
            DW_PF:     rdata = {st.pf_lim | PF_TYP, st.pf_base | PF_TYP};
            DW_PFB_HI: rdata = st.pf_base_hi;
            DW_PFL_HI: rdata = st.pf_lim_hi;
            DW_IO_HI:  rdata = {st.io_lim_hi, st.io_base_hi};
            DW_CTL:    rdata = {st.bctl, 16'h0000};
            default:   rdata = 32'h0;
        endcase
    end

endmodule

// File: rtl/bridge_cfg_regs.sv
module bridge_cfg_regs
    import bcfg_pkg::*;
#(
    parameter int   AW       = 4,
    parameter logic MULTI_FN = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_addr,
    input  logic          cfg_wr,
    input  logic [3:0]    cfg_be,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          fwd_close,
    output logic          map_update,
    output logic          sec_bus_rst
);
    typedef struct packed {
        regs_t r;
        logic  upd;
        logic  srst;
    } state_t;

    state_t st_d, st_q;
    logic   touch;

    bcfg_touch #(.AW(AW)) u_touch (
        .addr  (cfg_addr),
        .be    (cfg_be),
        .wr    (cfg_wr),
        .touch (touch)
    );

    bcfg_rdmux #(.AW(AW), .MULTI_FN(MULTI_FN)) u_rdmux (
        .st    (st_q.r),
        .addr  (cfg_addr),
        .rdata (cfg_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            case (int'(cfg_addr))
                DW_CMD: st_d.r.cmd = mrg16(st_q.r.cmd, cfg_wdata[15:0], cfg_be[1:0], CMD_WM);
                DW_BUS: begin
                    st_d.r.pri_bus = mrg8(st_q.r.pri_bus, cfg_wdata[7:0],   cfg_be[0], 8'hFF);
                    st_d.r.sec_bus = mrg8(st_q.r.sec_bus, cfg_wdata[15:8],  cfg_be[1], 8'hFF);
                    st_d.r.sub_bus = mrg8(st_q.r.sub_bus, cfg_wdata[23:16], cfg_be[2], 8'hFF);
                    st_d.r.sec_lat = mrg8(st_q.r.sec_lat, cfg_wdata[31:24], cfg_be[3], 8'hFF);
                end
                DW_IO: begin
                    st_d.r.io_base = mrg8(st_q.r.io_base, cfg_wdata[7:0],  cfg_be[0], IO_WM);
                    st_d.r.io_lim  = mrg8(st_q.r.io_lim,  cfg_wdata[15:8], cfg_be[1], IO_WM);
                end
                DW_MEM: begin
                    st_d.r.mem_base = mrg16(st_q.r.mem_base, cfg_wdata[15:0],  cfg_be[1:0], MEM_WM);
                    st_d.r.mem_lim  = mrg16(st_q.r.mem_lim,  cfg_wdata[31:16], cfg_be[3:2], MEM_WM);
                end
                DW_PF: begin
                    st_d.r.pf_base = mrg16(st_q.r.pf_base, cfg_wdata[15:0],  cfg_be[1:0], PF_WM);
                    st_d.r.pf_lim  = mrg16(st_q.r.pf_lim,  cfg_wdata[31:16], cfg_be[3:2], PF_WM);
                end
                DW_PFB_HI: st_d.r.pf_base_hi = mrg32(st_q.r.pf_base_hi, cfg_wdata, cfg_be);
                DW_PFL_HI: st_d.r.pf_lim_hi  = mrg32(st_q.r.pf_lim_hi,  cfg_wdata, cfg_be);
                DW_IO_HI: begin
                    st_d.r.io_base_hi = mrg16(st_q.r.io_base_hi, cfg_wdata[15:0],  cfg_be[1:0], 16'hFFFF);
                    st_d.r.io_lim_hi  = mrg16(st_q.r.io_lim_hi,  cfg_wdata[31:16], cfg_be[3:2], 16'hFFFF);
                end
                DW_CTL: st_d.r.bctl = mrg16(st_q.r.bctl, cfg_wdata[31:16], cfg_be[3:2], CTL_WM);
                default: ;
            endcase
        end
        // closing the windows overrides a same-cycle write to them
        if (fwd_close) begin
            st_d.r.io_base    = st_d.r.io_base  | IO_WM;
            st_d.r.io_lim     = st_d.r.io_lim   & ~IO_WM;
            st_d.r.mem_base   = st_d.r.mem_base | MEM_WM;
            st_d.r.mem_lim    = st_d.r.mem_lim  & ~MEM_WM;
            st_d.r.pf_base    = st_d.r.pf_base  | PF_WM;
            st_d.r.pf_lim     = st_d.r.pf_lim   & ~PF_WM;
            st_d.r.pf_base_hi = '0;
            st_d.r.pf_lim_hi  = '0;
        end
        st_d.upd  = touch;
        st_d.srst = st_d.r.bctl[CTL_SBR] & ~st_q.r.bctl[CTL_SBR];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign map_update  = st_q.upd;
    assign sec_bus_rst = st_q.srst;

    // strobe only ever follows a port write
    assert_update_from_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        map_update |-> $past(cfg_wr));

    // the bus reset bit lives in a window-affecting word
    assert_reset_with_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_bus_rst |-> map_update);

    assert_reset_bit_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sec_bus_rst |-> st_q.r.bctl[CTL_SBR]);

    assert_reset_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sec_bus_rst |=> !sec_bus_rst);

    assert_close_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fwd_close) |-> (st_q.r.mem_lim[15:4] == '0 && st_q.r.pf_lim_hi == '0 &&
                              st_q.r.io_base[7:4] == 4'hF));

endmodule

// File: tb/bridge_cfg_regs_tb.sv
module bridge_cfg_regs_tb;
    localparam int   AW = 4;
    localparam logic MF = 1'b1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic          cfg_wr = 1'b0;
    logic [3:0]    cfg_be = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          fwd_close = 1'b0;
    logic          map_update;
    logic          sec_bus_rst;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mem [64];

    always #4 clk = ~clk;

    bridge_cfg_regs #(.AW(AW), .MULTI_FN(MF)) u_dut (
        .clk, .rst_n, .cfg_addr, .cfg_wr, .cfg_be, .cfg_wdata, .cfg_rdata,
        .fwd_close, .map_update, .sec_bus_rst
    );

    function automatic logic [7:0] wm_of(int b);
        if (b == 4) return 8'h07;
        if (b >= 24 && b <= 27) return 8'hFF;
        if (b == 28 || b == 29) return 8'hF0;
        if (b >= 32 && b <= 39) return (b % 2 == 0) ? 8'hF0 : 8'hFF;
        if (b >= 40 && b <= 51) return 8'hFF;
        if (b == 62) return 8'h7F;
        return 8'h00;
    endfunction

    function automatic logic [7:0] ro_of(int b);
        case (b)
            6, 30:      return 8'hA0;
            10:         return 8'h04;
            11:         return 8'h06;
            14:         return {MF, 7'h01};
            28, 29, 36, 38: return 8'h01;
            default:    return 8'h00;
        endcase
    endfunction

    function automatic logic touch_of(int b);
        return b == 4 || b == 5 || b == 28 || b == 29 || (b >= 32 && b <= 51) ||
               b == 62 || b == 63;
    endfunction

    function automatic logic [31:0] exp_read(int dw);
        logic [31:0] v;
        for (int k = 0; k < 4; k++) v[8*k +: 8] = mem[dw*4+k] | ro_of(dw*4+k);
        return v;
    endfunction

    function automatic string req_of(int dw);
        case (dw)
            1:       return "R4";
            2, 3:    return "R6";
            6:       return "R2";
            7, 8, 9, 10, 11, 12: return "R3";
            15:      return "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_all(string tag);
        for (int d = 0; d < 16; d++) begin
            cfg_addr = AW'(d);
            #1;
            chk(tag.len() > 0 ? tag : req_of(d), cfg_rdata, exp_read(d));
        end
    endtask

    // one clocked operation; the model is updated in the same order as the requirements
    task automatic op(int dw, logic [3:0] be, logic [31:0] d, logic wr, logic cls);
        logic old_sbr, exp_upd, exp_srst;
        @(negedge clk);
        cfg_addr = AW'(dw); cfg_be = be; cfg_wdata = d; cfg_wr = wr; fwd_close = cls;
        old_sbr = mem[62][6];
        exp_upd = 1'b0;
        if (wr) begin
            for (int k = 0; k < 4; k++) begin
                int b = dw*4 + k;
                if (be[k]) begin
                    if (touch_of(b)) exp_upd = 1'b1;
                    mem[b] = (mem[b] & ~wm_of(b)) | (d[8*k +: 8] & wm_of(b));
                end
            end
        end
        if (cls) begin
            foreach (mem[b]) begin
                if (b == 28 || b == 32 || b == 33 || b == 36 || b == 37) mem[b] = mem[b] | wm_of(b);
                if (b == 29 || b == 34 || b == 35 || b == 38 || b == 39) mem[b] = mem[b] & ~wm_of(b);
                if (b >= 40 && b <= 47) mem[b] = 8'h00;
            end
        end
        exp_srst = ~old_sbr & mem[62][6];
        @(posedge clk);
        #1;
        cfg_wr = 1'b0; fwd_close = 1'b0;
        chk("R8", 32'(map_update), 32'(exp_upd));
        chk("R9", 32'(sec_bus_rst), 32'(exp_srst));
        cfg_addr = AW'(dw);
        #1;
        chk(cls ? "R10" : req_of(dw), cfg_rdata, exp_read(dw));
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd2024);
        foreach (mem[b]) mem[b] = 8'h00;
        #10;
        read_all("R1");                         // during reset
        chk("R1", 32'(map_update), 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        read_all("R1");                         // after release, before any write

        // R2: byte lanes of the bus-number dword
        op(6, 4'b0101, 32'hA1B2_C3D4, 1'b1, 1'b0);
        op(6, 4'b1010, 32'h1122_3344, 1'b1, 1'b0);
        // R3: all-ones into every window field
        for (int d = 7; d <= 12; d++) op(d, 4'hF, 32'hFFFF_FFFF, 1'b1, 1'b0);
        // R4: command mask
        op(1, 4'hF, 32'hFFFF_FFFF, 1'b1, 1'b0);
        // R9: bus reset rising edge, then rewrite while set
        op(15, 4'b1100, 32'hFFFF_FFFF, 1'b1, 1'b0);
        op(15, 4'b1100, 32'hFFFF_FFFF, 1'b1, 1'b0);
        op(15, 4'b1100, 32'h0000_0000, 1'b1, 1'b0);
        // R9: bit 6 sits in lane 2, so a lane-3-only write gives no pulse
        op(15, 4'b1000, 32'h0040_0000, 1'b1, 1'b0);
        op(15, 4'b0100, 32'h0040_0000, 1'b1, 1'b0);
        // R7: unimplemented dword and low lanes of dword 15
        op(5, 4'hF, 32'hDEAD_BEEF, 1'b1, 1'b0);
        op(15, 4'b0011, 32'hFFFF_FFFF, 1'b1, 1'b0);
        op(0, 4'hF, 32'hFFFF_FFFF, 1'b1, 1'b0);
        // R10: close alongside a write to the limit, then close alone
        op(8, 4'hF, 32'hFFFF_0000, 1'b1, 1'b1);
        op(9, 4'h0, 32'h0, 1'b0, 1'b1);
        read_all("R10");
        // R6: identity fields are not writable
        op(2, 4'hF, 32'h0, 1'b1, 1'b0);
        op(3, 4'hF, 32'h0, 1'b1, 1'b0);

        for (int i = 0; i < 2000; i++) begin
            op(int'($urandom_range(15, 0)), 4'($urandom), $urandom,
               1'($urandom_range(3, 0) != 0), 1'($urandom_range(15, 0) == 0));
        end
        read_all("");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule